// File: doc/BRIEF.md
# Disk Pack Controller Status and Interrupt Unit

This unit keeps the two 18-bit status words of a multi-drive disk pack controller. Programmed-I/O commands arrive as a one-cycle `cmdValid` with a 4-bit opcode. They test the status and raise a skip response, read either word, change the writable control field of status word A, clear the sticky error flags, or reset the controller. The unit combines the sticky flags with per-drive conditions of the currently selected drive, which are rebuilt every cycle. From these it forms the error summary bit and the single interrupt request.

The transfer engine, drive timing and memory access are elsewhere. They reach this unit only as a busy level, a done-set strobe, error-set strobes and per-drive attention strobes. The selected unit number is driven out so that the surrounding logic can route that drive's state signals back in. Commands take effect at the clock edge on which `cmdValid` is high. Read data, skip and interrupt are combinational on the current state.

Top module: `dpk_status_unit`

## Requirements
- R1: After `rstN` low, or after opcode 10 (controller reset, accepted even while busy and winning over every set strobe in the same cycle), all sticky and writable bits of both words are 0 and `irq` is 0.
- R2: Opcode 9 replaces word A bits 17:9 with `cmdData[17:9]`, opcode 7 ANDs them with it, and opcode 8 ORs them with it. Word A bits 8:0 are never written by these.
- R3: Opcodes 6 to 9, issued while `ctlBusy` is high, leave word A bits 17:9 and every clearable flag unchanged and set the programming error flag (word B bit 8).
- R4: Opcode 6 clears word A bits 4 (header not found) and 1 (done), and word B bits 8:2. It leaves word A bits 8:5 and the word B attention field unchanged.
- R5: A set strobe (`doneSet` to A bit 1, `errSetA[k]` to A bit 4+k, `errSetB[k]` to B bit 2+k) in the same cycle as opcode 6 leaves its flag set.
- R6: Word A bit 0 is 1 exactly when any of A bits 8:4, A bit 2, B bit 9 or B bits 8:2 is 1.
- R7: `irq` is 1 when (A bit 0 or A bit 1) and A bit 11 are set, or when any of B bits 17:10 is set and A bit 10 is set. Otherwise it is 0.
- R8: From the selected drive: A bit 3 = write protected. A detached drive shows B bits 9 and 0. An attached seeking drive shows B bits 1 and 0. An attached, non-seeking drive past its cylinder limit shows A bit 2.
- R9: While `cmdValid` is high, `skip` is 1 for opcode 0 when done, error or any attention is set; for opcode 1 on attention; for opcode 2 on done; for opcode 3 on error. Otherwise `skip` is 0.
- R10: `rdData` carries word A for opcode 4 and word B for opcode 5 while `cmdValid` is high. Otherwise it is 0.
- R11: An `attnSet[u]` strobe sets word B bit 17-u, which stays set until reset.
- R12: `selUnit` equals word A bits 17:15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 4 | Command opcode (0-3 tests, 4/5 reads, 6 clear, 7/8/9 loads, 10 reset) |
| cmdData | input | 18 | Command data word |
| ctlBusy | input | 1 | Controller busy with a started function |
| doneSet | input | 1 | Strobe: set done |
| errSetA | input | 5 | Strobes for word A sticky errors, bits 8:4 |
| errSetB | input | 7 | Strobes for word B sticky errors, bits 8:2 |
| attnSet | input | NUM_DRIVES | Per-drive attention strobes |
| drvAttached | input | 1 | Selected drive has media attached |
| drvWriteProt | input | 1 | Selected drive is write protected |
| drvSeeking | input | 1 | Selected drive is seeking or recalibrating |
| drvCylOver | input | 1 | Selected drive's cylinder is at or past its limit |
| rdData | output | 18 | Read data for opcodes 4 and 5 |
| skip | output | 1 | Skip response for test opcodes |
| irq | output | 1 | Interrupt request |
| selUnit | output | 3 | Selected drive number |

## Verification
The writable field is loaded with full, zero-mask and one-mask patterns whose bits are chosen to differ bit by bit. This separates replace from AND from OR and shows that the low nine data bits are dropped. The error and done paths are driven separately from the attention path, so each interrupt source is seen alone. A clear collides in one cycle with done and error strobes, and a controller reset collides with a done strobe, which exposes the wrong priority. The selected-drive inputs are toggled one at a time so that each dynamic bit, and its effect on the error summary, is seen alone.

// File: rtl/dpk_status_pkg.sv
package dpk_status_pkg;
  localparam int WORD_W   = 18;
  localparam int FIELD_LO = 9;
  localparam int FIELD_W  = WORD_W - FIELD_LO;
  localparam int ERRA_W   = 5;
  localparam int ERRB_W   = 7;
  localparam int ATTN_W   = 8;
  localparam int UNIT_W   = 3;

  typedef enum logic [3:0] {
    OP_TEST_ANY  = 4'd0,
    OP_TEST_ATTN = 4'd1,
    OP_TEST_DONE = 4'd2,
    OP_TEST_ERR  = 4'd3,
    OP_READ_A    = 4'd4,
    OP_READ_B    = 4'd5,
    OP_CLEAR     = 4'd6,
    OP_LOAD_ZERO = 4'd7,
    OP_LOAD_ONE  = 4'd8,
    OP_LOAD_FULL = 4'd9,
    OP_RESET     = 4'd10
  } cmdOp_e;

  typedef struct packed {
    logic ldZero;
    logic ldOne;
    logic ldFull;
    logic clrSts;
    logic devReset;
    logic progErr;
  } statStrobe_t;
endpackage

// File: rtl/dpk_status_ctrl.sv
module dpk_status_ctrl
  import dpk_status_pkg::*;
(
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic              ctlBusy,
  input  logic              flagDone,
  input  logic              flagErr,
  input  logic              flagAttn,
  input  logic [WORD_W-1:0] wordA,
  input  logic [WORD_W-1:0] wordB,
  output statStrobe_t       strobe,
  output logic              skip,
  output logic [WORD_W-1:0] rdData
);
  cmdOp_e op;
  logic   isWrite;

  assign op      = cmdOp_e'(cmdOp);
  assign isWrite = (op == OP_CLEAR) || (op == OP_LOAD_ZERO) ||
                   (op == OP_LOAD_ONE) || (op == OP_LOAD_FULL);

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      if (op == OP_RESET) begin
        strobe.devReset = 1'b1;
      end else if (isWrite && ctlBusy) begin
        strobe.progErr = 1'b1;
      end else begin
        unique case (op)
          OP_CLEAR:     strobe.clrSts = 1'b1;
          OP_LOAD_ZERO: strobe.ldZero = 1'b1;
          OP_LOAD_ONE:  strobe.ldOne  = 1'b1;
          OP_LOAD_FULL: strobe.ldFull = 1'b1;
          default:      ;
        endcase
      end
    end
  end

  always_comb begin
    skip = 1'b0;
    if (cmdValid) begin
      unique case (op)
        OP_TEST_ANY:  skip = flagDone | flagErr | flagAttn;
        OP_TEST_ATTN: skip = flagAttn;
        OP_TEST_DONE: skip = flagDone;
        OP_TEST_ERR:  skip = flagErr;
        default:      skip = 1'b0;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    if (cmdValid) begin
      if (op == OP_READ_A)      rdData = wordA;
      else if (op == OP_READ_B) rdData = wordB;
    end
  end
endmodule

// File: rtl/dpk_status_regs.sv
module dpk_status_regs
  import dpk_status_pkg::*;
#(
  parameter int NUM_DRIVES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  statStrobe_t           strobe,
  input  logic [WORD_W-1:0]     cmdData,
  input  logic                  doneSet,
  input  logic [ERRA_W-1:0]     errSetA,
  input  logic [ERRB_W-1:0]     errSetB,
  input  logic [NUM_DRIVES-1:0] attnSet,
  input  logic                  drvAttached,
  input  logic                  drvWriteProt,
  input  logic                  drvSeeking,
  input  logic                  drvCylOver,
  output logic [WORD_W-1:0]     wordA,
  output logic [WORD_W-1:0]     wordB,
  output logic                  flagDone,
  output logic                  flagErr,
  output logic                  flagAttn,
  output logic                  irq,
  output logic [UNIT_W-1:0]     selUnit
);
  localparam int IED_IDX = 2;
  localparam int IEA_IDX = 1;
  localparam int HNF_IDX = 0;
  localparam int PGE_IDX = ERRB_W - 1;

  logic [FIELD_W-1:0] ctlField;
  logic [ERRA_W-1:0]  stickyA;
  logic [ERRB_W-1:0]  stickyB;
  logic [ATTN_W-1:0]  attnField;
  logic               doneR;

  logic [FIELD_W-1:0] dataField;
  logic [FIELD_W-1:0] fieldNext;
  logic [ATTN_W-1:0]  attnSetMap;
  logic [ERRA_W-1:0]  clrMaskA;

  assign dataField = cmdData[WORD_W-1:FIELD_LO];

  // Drive u lands on the attention bit counted down from the top
  for (genvar g = 0; g < ATTN_W; g++) begin : g_attn
    if (g < NUM_DRIVES) begin : g_used
      assign attnSetMap[ATTN_W-1-g] = attnSet[g];
    end else begin : g_unused
      assign attnSetMap[ATTN_W-1-g] = 1'b0;
    end
  end

  always_comb begin
    fieldNext = ctlField;
    if (strobe.ldFull)      fieldNext = dataField;
    else if (strobe.ldZero) fieldNext = ctlField & dataField;
    else if (strobe.ldOne)  fieldNext = ctlField | dataField;
  end

  always_comb begin
    clrMaskA = '1;
    if (strobe.clrSts) clrMaskA[HNF_IDX] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlField  <= '0;
      stickyA   <= '0;
      stickyB   <= '0;
      attnField <= '0;
      doneR     <= 1'b0;
    end else if (strobe.devReset) begin
      ctlField  <= '0;
      stickyA   <= '0;
      stickyB   <= '0;
      attnField <= '0;
      doneR     <= 1'b0;
    end else begin
      ctlField  <= fieldNext;
      stickyA   <= (stickyA & clrMaskA) | errSetA;
      stickyB   <= (strobe.clrSts ? '0 : stickyB) | errSetB |
                   (ERRB_W'(strobe.progErr) << PGE_IDX);
      attnField <= attnField | attnSetMap;
      doneR     <= (doneR & ~strobe.clrSts) | doneSet;
    end
  end

  // Conditions of the selected drive, rebuilt every cycle
  logic dynWrLock, dynSeekInc, dynUnsafe, dynSeeking, dynNotRdy;
  assign dynWrLock  = drvWriteProt;
  assign dynUnsafe  = ~drvAttached;
  assign dynSeeking = drvAttached & drvSeeking;
  assign dynNotRdy  = dynUnsafe | dynSeeking;
  assign dynSeekInc = drvAttached & ~drvSeeking & drvCylOver;

  logic errSum;
  assign errSum = (|stickyA) | dynSeekInc | dynUnsafe | (|stickyB);

  assign wordA = {ctlField, stickyA, dynWrLock, dynSeekInc, doneR, errSum};
  assign wordB = {attnField, dynUnsafe, stickyB, dynSeeking, dynNotRdy};

  assign flagDone = doneR;
  assign flagErr  = errSum;
  assign flagAttn = |attnField;
  assign irq      = ((errSum | doneR) & ctlField[IED_IDX]) |
                    ((|attnField) & ctlField[IEA_IDX]);
  assign selUnit  = ctlField[FIELD_W-1 -: UNIT_W];
endmodule

// File: rtl/dpk_status_unit.sv
module dpk_status_unit
  import dpk_status_pkg::*;
#(
  parameter int NUM_DRIVES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [3:0]            cmdOp,
  input  logic [17:0]           cmdData,
  input  logic                  ctlBusy,
  input  logic                  doneSet,
  input  logic [4:0]            errSetA,
  input  logic [6:0]            errSetB,
  input  logic [NUM_DRIVES-1:0] attnSet,
  input  logic                  drvAttached,
  input  logic                  drvWriteProt,
  input  logic                  drvSeeking,
  input  logic                  drvCylOver,
  output logic [17:0]           rdData,
  output logic                  skip,
  output logic                  irq,
  output logic [2:0]            selUnit
);
  statStrobe_t       strobe;
  logic [WORD_W-1:0] statusA;
  logic [WORD_W-1:0] statusB;
  logic              flagDone, flagErr, flagAttn;

  dpk_status_ctrl i_ctrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .ctlBusy  (ctlBusy),
    .flagDone (flagDone),
    .flagErr  (flagErr),
    .flagAttn (flagAttn),
    .wordA    (statusA),
    .wordB    (statusB),
    .strobe   (strobe),
    .skip     (skip),
    .rdData   (rdData)
  );

  dpk_status_regs #(.NUM_DRIVES(NUM_DRIVES)) i_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cmdData      (cmdData),
    .doneSet      (doneSet),
    .errSetA      (errSetA),
    .errSetB      (errSetB),
    .attnSet      (attnSet),
    .drvAttached  (drvAttached),
    .drvWriteProt (drvWriteProt),
    .drvSeeking   (drvSeeking),
    .drvCylOver   (drvCylOver),
    .wordA        (statusA),
    .wordB        (statusB),
    .flagDone     (flagDone),
    .flagErr      (flagErr),
    .flagAttn     (flagAttn),
    .irq          (irq),
    .selUnit      (selUnit)
  );
endmodule

// File: rtl/dpk_status_chk.sv
module dpk_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [3:0]  cmdOp,
  input logic        ctlBusy,
  input logic        doneSet,
  input logic        drvAttached,
  input logic [17:0] statusA,
  input logic [17:0] statusB,
  input logic        irq
);
  // R1
  ctl_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 4'd10 |=>
      statusA[17:4] == '0 && !statusA[1] && statusB[17:10] == '0 && statusB[8:2] == '0);

  // R3
  busy_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && ctlBusy && (cmdOp inside {4'd6, 4'd7, 4'd8, 4'd9}) |=>
      statusB[8] && statusA[17:9] == $past(statusA[17:9]));

  // R4
  clear_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 4'd6 && !ctlBusy && !doneSet |=> !statusA[1]);

  // R6
  err_summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusB[8:2] != '0 |-> statusA[0]);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusA[11] && !statusA[10] |-> !irq);

  // R8
  detached_chk: assert property (@(posedge clk) disable iff (!rstN)
    !drvAttached |-> statusB[9] && statusB[0]);
endmodule

bind dpk_status_unit dpk_status_chk i_chk (.*);

// File: tb/test_dpk_status_unit.sv
`timescale 1ns/1ps
module test_dpk_status_unit;
  localparam logic [3:0] T_ANY = 4'd0, T_ATTN = 4'd1, T_DONE = 4'd2, T_ERR = 4'd3;
  localparam logic [3:0] RD_A = 4'd4, RD_B = 4'd5, CLR = 4'd6;
  localparam logic [3:0] LD_Z = 4'd7, LD_O = 4'd8, LD_F = 4'd9, RST = 4'd10;
  localparam int K_RD = 0, K_SKIP = 1, K_IRQ = 2, K_SEL = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [3:0]  cmdOp;
  logic [17:0] cmdData;
  logic        ctlBusy, doneSet;
  logic [4:0]  errSetA;
  logic [6:0]  errSetB;
  logic [7:0]  attnSet;
  logic        drvAttached, drvWriteProt, drvSeeking, drvCylOver;
  logic [17:0] rdData;
  logic        skip, irq;
  logic [2:0]  selUnit;

  always #2 clk = ~clk;

  dpk_status_unit i_dpk_status_unit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .ctlBusy(ctlBusy), .doneSet(doneSet), .errSetA(errSetA), .errSetB(errSetB),
    .attnSet(attnSet), .drvAttached(drvAttached), .drvWriteProt(drvWriteProt),
    .drvSeeking(drvSeeking), .drvCylOver(drvCylOver), .rdData(rdData), .skip(skip),
    .irq(irq), .selUnit(selUnit)
  );

  typedef struct {
    string       req;
    int          kind;
    logic [17:0] exp;
  } item_t;

  item_t sbq[$];
  event  sampleEv;
  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 0;

  // Monitor: pops expectations and compares with the outputs
  initial forever begin
    @(sampleEv);
    while (sbq.size() > 0) begin
      item_t it;
      logic [17:0] act;
      it = sbq.pop_front();
      case (it.kind)
        K_RD:    act = rdData;
        K_SKIP:  act = {17'd0, skip};
        K_IRQ:   act = {17'd0, irq};
        default: act = {15'd0, selUnit};
      endcase
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic peek(string req, int kind, bit useCmd, logic [3:0] op, logic [17:0] exp);
    cmdValid = useCmd;
    cmdOp    = op;
    #1;
    sbq.push_back('{req, kind, exp});
    ->sampleEv;
    #1;
    cmdValid = 1'b0;
  endtask

  task automatic rdA(string req, logic [17:0] exp);
    peek(req, K_RD, 1'b1, RD_A, exp);
  endtask

  task automatic rdB(string req, logic [17:0] exp);
    peek(req, K_RD, 1'b1, RD_B, exp);
  endtask

  task automatic issue(logic [3:0] op, logic [17:0] data);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdData  = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pulse(logic dn, logic [4:0] ea, logic [6:0] eb, logic [7:0] at);
    @(negedge clk);
    doneSet = dn; errSetA = ea; errSetB = eb; attnSet = at;
    @(negedge clk);
    doneSet = 0; errSetA = '0; errSetB = '0; attnSet = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; cmdValid = 0; cmdOp = '0; cmdData = '0; ctlBusy = 0;
    doneSet = 0; errSetA = '0; errSetB = '0; attnSet = '0;
    drvAttached = 1; drvWriteProt = 0; drvSeeking = 0; drvCylOver = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    rdA("R1 reset A", 18'h0);
    rdB("R1 reset B", 18'h0);
    peek("R1 reset irq", K_IRQ, 0, 4'd0, 18'h0);

    // R2 full load, only bits 17:9 land
    issue(LD_F, 18'h3FFFF);
    rdA("R2 load full", 18'h3FE00);
    peek("R12 unit select", K_SEL, 0, 4'd0, 18'h7);
    // R2 zero-mask load
    issue(LD_Z, 18'h2ABFF);
    rdA("R2 load zeros", 18'h2AA00);
    // R2 one-mask load
    issue(LD_O, 18'h105FF);
    rdA("R2 load ones", 18'h3AE00);
    peek("R7 enables without flags", K_IRQ, 0, 4'd0, 18'h0);

    // done flag, interrupt and skip tests
    pulse(1, '0, '0, '0);
    rdA("R5 done set", 18'h3AE02);
    peek("R7 irq on done", K_IRQ, 0, 4'd0, 18'h1);
    peek("R9 skip done", K_SKIP, 1, T_DONE, 18'h1);
    peek("R9 skip any", K_SKIP, 1, T_ANY, 18'h1);
    peek("R9 skip err clear", K_SKIP, 1, T_ERR, 18'h0);
    peek("R9 skip attn clear", K_SKIP, 1, T_ATTN, 18'h0);
    issue(LD_F, 18'h0);
    rdA("R2 full load zero", 18'h00002);
    peek("R7 irq off when disabled", K_IRQ, 0, 4'd0, 18'h0);

    // R6 sticky B error drives summary
    pulse(0, '0, 7'b0010000, '0);
    rdB("R6 timing flag", 18'h00040);
    rdA("R6 error summary", 18'h00003);
    peek("R9 skip err", K_SKIP, 1, T_ERR, 18'h1);

    // R3 write while busy
    ctlBusy = 1;
    issue(LD_F, 18'h3FFFF);
    ctlBusy = 0;
    rdA("R3 busy load ignored", 18'h00003);
    rdB("R3 programming error", 18'h00140);

    // R11 attention of drive 2 on bit 15
    pulse(0, '0, '0, 8'b00000100);
    rdB("R11 attention drive 2", 18'h08140);
    peek("R9 skip attn", K_SKIP, 1, T_ATTN, 18'h1);

    // sticky A flags
    pulse(0, 5'b01001, '0, '0);
    rdA("R5 sticky A set", 18'h00093);

    // R4 clear status
    issue(CLR, 18'h0);
    rdA("R4 clear A", 18'h00081);
    rdB("R4 clear B", 18'h08000);

    // R5 set beats clear
    @(negedge clk);
    cmdValid = 1; cmdOp = CLR; doneSet = 1; errSetB = 7'b0000100;
    @(negedge clk);
    cmdValid = 0; doneSet = 0; errSetB = '0;
    rdA("R5 done survives clear", 18'h00083);
    rdB("R5 error survives clear", 18'h08010);

    // R8 selected drive conditions
    drvAttached = 0;
    rdB("R8 detached", 18'h08211);
    drvAttached = 1; drvSeeking = 1;
    rdB("R8 seeking", 18'h08013);
    drvSeeking = 0; drvCylOver = 1;
    rdA("R8 seek incomplete", 18'h00087);
    drvCylOver = 0; drvWriteProt = 1;
    rdA("R8 write locked", 18'h0008B);
    drvWriteProt = 0;

    // R7 interrupt sources
    issue(LD_F, 18'h00400);
    rdA("R7 attn enable", 18'h00483);
    peek("R7 irq on attention", K_IRQ, 0, 4'd0, 18'h1);
    issue(LD_F, 18'h00800);
    peek("R7 irq on error", K_IRQ, 0, 4'd0, 18'h1);
    issue(LD_F, 18'h18000);
    peek("R12 unit 3", K_SEL, 0, 4'd0, 18'h3);
    peek("R7 irq off", K_IRQ, 0, 4'd0, 18'h0);

    // R1 controller reset beats done strobe
    @(negedge clk);
    cmdValid = 1; cmdOp = RST; doneSet = 1;
    @(negedge clk);
    cmdValid = 0; doneSet = 0;
    rdA("R1 ctl reset A", 18'h0);
    rdB("R1 ctl reset B", 18'h0);
    peek("R1 ctl reset irq", K_IRQ, 0, 4'd0, 18'h0);

    // R6 from dynamic seek incomplete alone
    drvCylOver = 1;
    rdA("R6 summary from seek incomplete", 18'h00005);
    drvCylOver = 0;

    // R10 read data idle
    peek("R10 no command", K_RD, 0, RD_A, 18'h0);
    issue(LD_F, 18'h3FE00);
    peek("R10 non-read opcode", K_RD, 1, T_ANY, 18'h0);
    peek("R9 no skip without cmd", K_SKIP, 0, T_ANY, 18'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule